// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a 32-bit core and a word-addressed 32-bit memory port. It takes one memory request per cycle, described by an operation code, a base register value, a 16-bit signed displacement and, for stores, a source register value. From these it forms the effective address and drives a word address, byte-lane enables, a write strobe and write data toward memory. On loads, it takes the word the memory returns, picks out the lane that was addressed, and extends it to 32 bits.

Lanes are numbered big-endian. Byte offset 0 of a word is in bits 31:24 and byte offset 3 is in bits 7:0. The operation code alone decides the access size, the direction and, for loads, whether the value is sign-extended or zero-extended. Global-pointer-relative accesses are ordinary displacement accesses and get no special treatment. A halfword or word access that is not aligned to its size is not sent to memory. It raises a one-cycle misalignment flag instead.

All outputs come from registers. The memory outputs appear in the cycle after the request. The memory must present read data in the cycle after `mem_valid`. The extended load result appears in the cycle after that.

Top module: `mem_lane_aligner`

## Requirements
- R1: The effective address is `req_base` plus `req_disp` sign-extended to 32 bits, taken modulo 2^32. `mem_addr` carries bits 31:2 of that address in the cycle after the request.
- R2: Byte enables are big-endian. A byte access at offsets 0, 1, 2, 3 drives 1000, 0100, 0010, 0001. A halfword access at offset 0 drives 1100 and at offset 2 drives 0011. A word access drives 1111. Loads drive the same enables with `mem_we` low.
- R3: Stores are opcode 12 (byte), 3 (halfword) and 22 (word), and they drive `mem_we` high. A byte store repeats bits 7:0 of the source in all four lanes. A halfword store repeats bits 15:0 in both halves. A word store passes the source through unchanged.
- R4: Loads select the addressed lane. Byte offset k is taken from bits 31-8k down to 24-8k. A halfword at offset 0 comes from bits 31:16 and at offset 2 from bits 15:0.
- R5: Opcode 4 (byte) and opcode 7 (halfword) sign-extend. Opcode 16 (byte) and opcode 11 (halfword) zero-extend. Opcode 10 returns the whole word. `ld_valid` and `ld_data` appear two cycles after `mem_valid`.
- R6: A halfword at an odd address, or a word at an address that is not a multiple of 4, raises `misalign` for one cycle. It leaves `mem_valid` low and the enables at 0000, and it produces no `ld_valid`.
- R7: A request with `req_valid` low, or with any opcode other than the eight above, produces no `mem_valid`, no `misalign` and no `ld_valid`.
- R8: While `rst` is high, `mem_valid`, `misalign` and `ld_valid` are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Operation code |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wsrc | input | 32 | Store source register value |
| mem_rdata | input | 32 | Read word, valid the cycle after a load's `mem_valid` |
| mem_valid | output | 1 | Memory access issued |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte-lane enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Replicated write data |
| misalign | output | 1 | Request rejected as misaligned |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
Some properties are checked on every cycle. Enables always take one of the seven legal shapes. Store data repeats across lanes whenever the enables cover one byte or one half. `misalign` and `mem_valid` are never high together. Every `ld_valid` follows a read issue by exactly two cycles. Reset quiets all flags. Other properties need the bench's address sweep over every opcode, lane and displacement sign: that each enable and data pattern lands on the right offset, that the correct lane is extracted, and that the extension matches the opcode. Wraparound addressing and dropped requests also come only from the bench's scenarios.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int OPC_W  = 6;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD} size_e;

  typedef struct packed {
    logic  legal;
    logic  is_load;
    logic  sext;
    size_e size;
  } opinfo_t;

  localparam logic [OPC_W-1:0] OPC_LDB_S = 6'd4;
  localparam logic [OPC_W-1:0] OPC_LDB_U = 6'd16;
  localparam logic [OPC_W-1:0] OPC_LDH_S = 6'd7;
  localparam logic [OPC_W-1:0] OPC_LDH_U = 6'd11;
  localparam logic [OPC_W-1:0] OPC_LDW   = 6'd10;
  localparam logic [OPC_W-1:0] OPC_STB   = 6'd12;
  localparam logic [OPC_W-1:0] OPC_STH   = 6'd3;
  localparam logic [OPC_W-1:0] OPC_STW   = 6'd22;

  function automatic opinfo_t decode_op(input logic [OPC_W-1:0] op);
    opinfo_t r;
    r = '{legal: 1'b1, is_load: 1'b0, sext: 1'b0, size: SZ_BYTE};
    case (op)
      OPC_LDB_S: begin r.is_load = 1'b1; r.sext = 1'b1; r.size = SZ_BYTE; end
      OPC_LDB_U: begin r.is_load = 1'b1; r.size = SZ_BYTE; end
      OPC_LDH_S: begin r.is_load = 1'b1; r.sext = 1'b1; r.size = SZ_HALF; end
      OPC_LDH_U: begin r.is_load = 1'b1; r.size = SZ_HALF; end
      OPC_LDW:   begin r.is_load = 1'b1; r.size = SZ_WORD; end
      OPC_STB:   r.size = SZ_BYTE;
      OPC_STH:   r.size = SZ_HALF;
      OPC_STW:   r.size = SZ_WORD;
      default:   r.legal = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  size_e             size_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              misalign_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  assign ea_o = base_i + {{EXT_W{disp_i[DISP_W-1]}}, disp_i};

  always_comb begin
    case (size_i)
      SZ_HALF: misalign_o = ea_o[0];
      SZ_WORD: misalign_o = |ea_o[OFF_W-1:0];
      default: misalign_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
  import lsa_pkg::*;
(
  input  size_e              size_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [WORD_W-1:0]  src_i,
  output logic [LANES-1:0]   be_o,
  output logic [WORD_W-1:0]  wdata_o
);
  // lane g is byte offset g, stored at bits WORD_W-1-8g downward (big-endian)
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HI = WORD_W - 1 - 8 * g;
    localparam logic [OFF_W-1:0] GOFF = OFF_W'(g);
    always_comb begin
      case (size_i)
        SZ_BYTE: begin
          be_o[LANES-1-g]     = (off_i == GOFF);
          wdata_o[HI -: 8]    = src_i[7:0];
        end
        SZ_HALF: begin
          be_o[LANES-1-g]     = (off_i[OFF_W-1] == GOFF[OFF_W-1]);
          wdata_o[HI -: 8]    = GOFF[0] ? src_i[7:0] : src_i[15:8];
        end
        default: begin
          be_o[LANES-1-g]     = 1'b1;
          wdata_o[HI -: 8]    = src_i[HI -: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
(
  input  size_e              size_i,
  input  logic               sext_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [WORD_W-1:0]  data_o
);
  logic [7:0]  lane [LANES];
  logic [7:0]  byte_v;
  logic [15:0] half_v;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lane[g] = word_i[WORD_W-1-8*g -: 8];
  end

  assign byte_v = lane[off_i];
  assign half_v = off_i[OFF_W-1] ? word_i[15:0] : word_i[WORD_W-1 -: 16];

  always_comb begin
    case (size_i)
      SZ_BYTE: data_o = {{(WORD_W-8){sext_i & byte_v[7]}}, byte_v};
      SZ_HALF: data_o = {{(WORD_W-16){sext_i & half_v[15]}}, half_v};
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [OPC_W-1:0]        req_op,
  input  logic [ADDR_W-1:0]       req_base,
  input  logic [DISP_W-1:0]       req_disp,
  input  logic [WORD_W-1:0]       req_wsrc,
  input  logic [WORD_W-1:0]       mem_rdata,
  output logic                    mem_valid,
  output logic                    mem_we,
  output logic [ADDR_W-OFF_W-1:0] mem_addr,
  output logic [LANES-1:0]        mem_be,
  output logic [WORD_W-1:0]       mem_wdata,
  output logic                    misalign,
  output logic                    ld_valid,
  output logic [WORD_W-1:0]       ld_data
);
  opinfo_t            info;
  logic [ADDR_W-1:0]  ea;
  logic               mis_c;
  logic               go;
  logic [LANES-1:0]   be_c;
  logic [WORD_W-1:0]  wd_c;
  logic [WORD_W-1:0]  ext_c;

  // request-side state carried to the load return path
  size_e              s1_size, s2_size;
  logic               s1_sext, s2_sext;
  logic [OFF_W-1:0]   s1_off,  s2_off;
  logic               s2_valid;

  assign info = decode_op(req_op);
  assign go   = req_valid & info.legal;

  lsa_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_ag (
    .base_i    (req_base),
    .disp_i    (req_disp),
    .size_i    (info.size),
    .ea_o      (ea),
    .misalign_o(mis_c)
  );

  lsa_store_lane u_st (
    .size_i (info.size),
    .off_i  (ea[OFF_W-1:0]),
    .src_i  (req_wsrc),
    .be_o   (be_c),
    .wdata_o(wd_c)
  );

  lsa_load_extract u_ld (
    .size_i(s2_size),
    .sext_i(s2_sext),
    .off_i (s2_off),
    .word_i(mem_rdata),
    .data_o(ext_c)
  );

  // issue stage
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      misalign  <= 1'b0;
      s1_size   <= SZ_BYTE;
      s1_sext   <= 1'b0;
      s1_off    <= '0;
    end else begin
      mem_valid <= go & ~mis_c;
      mem_we    <= go & ~mis_c & ~info.is_load;
      mem_be    <= (go & ~mis_c) ? be_c : '0;
      mem_addr  <= ea[ADDR_W-1:OFF_W];
      mem_wdata <= wd_c;
      misalign  <= go & mis_c;
      s1_size   <= info.size;
      s1_sext   <= info.sext;
      s1_off    <= ea[OFF_W-1:0];
    end
  end

  // memory read cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_size  <= SZ_BYTE;
      s2_sext  <= 1'b0;
      s2_off   <= '0;
    end else begin
      s2_valid <= mem_valid & ~mem_we;
      s2_size  <= s1_size;
      s2_sext  <= s1_sext;
      s2_off   <= s1_off;
    end
  end

  // load result stage
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= s2_valid;
      if (s2_valid) ld_data <= ext_c;
    end
  end
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker (
  input logic        clk,
  input logic        rst,
  input logic        mem_valid,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        misalign,
  input logic        ld_valid
);
  p_be_shape_r2: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> ($countones(mem_be) == 1 || mem_be == 4'b1100 ||
                   mem_be == 4'b0011 || mem_be == 4'b1111));

  p_byte_repl_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_we && $countones(mem_be) == 1) |->
      (mem_wdata[31:24] == mem_wdata[7:0] && mem_wdata[23:16] == mem_wdata[7:0] &&
       mem_wdata[15:8] == mem_wdata[7:0]));

  p_half_repl_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_we && $countones(mem_be) == 2) |->
      (mem_wdata[31:16] == mem_wdata[15:0]));

  p_ld_timing_r5: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> ($past(mem_valid, 2) && !$past(mem_we, 2)));

  p_misalign_excl_r6: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (!mem_valid && mem_be == 4'b0000));

  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |=> (!mem_valid && !misalign && !ld_valid));
endmodule

bind mem_lane_aligner lsa_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_valid(mem_valid),
  .mem_we   (mem_we),
  .mem_be   (mem_be),
  .mem_wdata(mem_wdata),
  .misalign (misalign),
  .ld_valid (ld_valid)
);

// File: tb/sim_mem_lane_aligner.sv
`timescale 1ns/1ps
module sim_mem_lane_aligner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [5:0]  req_op = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic [31:0] req_wsrc = '0;
  logic [31:0] mem_rdata;
  logic        mem_valid, mem_we, misalign, ld_valid;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, ld_data;

  int tests = 0;
  int failed = 0;
  bit done = 1'b0;

  logic [31:0] ram  [16];
  logic [31:0] shad [16];

  always #2.5 clk = ~clk;

  mem_lane_aligner u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_disp(req_disp), .req_wsrc(req_wsrc),
    .mem_rdata(mem_rdata), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  function automatic logic [31:0] pat(input int i);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[31-8*k -: 8] = 8'(i * 53 + k * 71 + 8'h35);
    return w;
  endfunction

  // synchronous-read memory model, one-cycle latency
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) ram[i] <= pat(i);
      mem_rdata <= '0;
    end else if (mem_valid) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[3-k]) ram[mem_addr[3:0]][31-8*k -: 8] <= mem_wdata[31-8*k -: 8];
      end else begin
        mem_rdata <= ram[mem_addr[3:0]];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // opcode -> size in bytes (0 = not an access), load flag, signed flag
  function automatic int op_size(input logic [5:0] op);
    case (op)
      6'd4, 6'd16, 6'd12: return 1;
      6'd7, 6'd11, 6'd3:  return 2;
      6'd10, 6'd22:       return 4;
      default:            return 0;
    endcase
  endfunction

  function automatic bit op_load(input logic [5:0] op);
    return op == 6'd4 || op == 6'd16 || op == 6'd7 || op == 6'd11 || op == 6'd10;
  endfunction

  function automatic bit op_signed(input logic [5:0] op);
    return op == 6'd4 || op == 6'd7;
  endfunction

  function automatic logic [3:0] exp_be(input int sz, input logic [1:0] off);
    if (sz == 1) return 4'b1000 >> off;
    if (sz == 2) return off[1] ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_wd(input int sz, input logic [31:0] s);
    if (sz == 1) return {4{s[7:0]}};
    if (sz == 2) return {2{s[15:0]}};
    return s;
  endfunction

  function automatic logic [31:0] exp_ld(input int sz, input bit sg, input logic [1:0] off,
                                         input logic [31:0] w);
    logic [31:0] v;
    if (sz == 1) begin
      v = (w >> (8 * (3 - off))) & 32'hFF;
      if (sg && v[7]) v = v | 32'hFFFF_FF00;
    end else if (sz == 2) begin
      v = (w >> (off[1] ? 0 : 16)) & 32'hFFFF;
      if (sg && v[15]) v = v | 32'hFFFF_0000;
    end else v = w;
    return v;
  endfunction

  task automatic run_req(input bit v, input logic [5:0] op, input logic [31:0] base,
                         input logic [15:0] disp, input logic [31:0] src);
    logic [31:0] ea;
    logic [1:0]  off;
    int          sz;
    bit          mis, issue, ld;
    ea    = base + {{16{disp[15]}}, disp};
    off   = ea[1:0];
    sz    = v ? op_size(op) : 0;
    mis   = (sz == 2 && off[0]) || (sz == 4 && off != 2'd0);
    issue = (sz != 0) && !mis;
    ld    = issue && op_load(op);
    @(negedge clk);
    req_valid = v; req_op = op; req_base = base; req_disp = disp; req_wsrc = src;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 mem_valid", 32'(mem_valid), 32'(issue));
    chk("R6 misalign",  32'(misalign), 32'(sz != 0 && mis));
    if (mis) chk("R6 enables suppressed", 32'(mem_be), 32'h0);
    if (issue) begin
      chk("R1 word address", 32'(mem_addr), 32'(ea[31:2]));
      chk("R2 byte enables", 32'(mem_be), 32'(exp_be(sz, off)));
      chk("R3 write strobe", 32'(mem_we), 32'(!op_load(op)));
      if (!op_load(op)) begin
        chk("R3 write data", mem_wdata, exp_wd(sz, src));
        for (int k = 0; k < 4; k++)
          if (exp_be(sz, off)[3-k])
            shad[ea[5:2]][31-8*k -: 8] = exp_wd(sz, src)[31-8*k -: 8];
      end
    end
    @(negedge clk);
    chk("R5 no early ld_valid", 32'(ld_valid), 32'h0);
    @(negedge clk);
    chk("R5 ld_valid", 32'(ld_valid), 32'(ld));
    if (ld) chk("R4 R5 load data", ld_data, exp_ld(sz, op_signed(op), off, shad[ea[5:2]]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [8];
    ops = '{6'd12, 6'd4, 6'd16, 6'd3, 6'd7, 6'd11, 6'd22, 6'd10};
    for (int i = 0; i < 16; i++) shad[i] = pat(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset mem_valid", 32'(mem_valid), 32'h0);
    chk("R8 reset misalign",  32'(misalign), 32'h0);
    chk("R8 reset ld_valid",  32'(ld_valid), 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // sweep: every opcode x word x byte offset, both displacement signs
    for (int o = 0; o < 8; o++)
      for (int w = 0; w < 4; w++)
        for (int f = 0; f < 4; f++) begin
          logic [31:0] ea, src;
          logic [15:0] d;
          ea  = 32'h40 + 32'(4 * w + f);
          d   = ((w + f) % 2 == 1) ? 16'hFFF9 : 16'd3;
          src = 32'h9C3E_7A85 ^ (32'(w) * 32'h0101_0101) ^ (32'(f) * 32'h1357_9BDF);
          run_req(1'b1, ops[o], ea - {{16{d[15]}}, d}, d, src);
        end

    // R1 wraparound and extreme displacements
    run_req(1'b1, 6'd10, 32'hFFFF_FFFE, 16'd6, 32'h0);
    run_req(1'b1, 6'd4, 32'h0000_0003, 16'hFFFD, 32'h0);
    run_req(1'b1, 6'd22, 32'h0000_8048, 16'h8000, 32'hDEAD_BEEF);
    run_req(1'b1, 6'd10, 32'h0000_0008, 16'd0, 32'h0);
    // R7 illegal opcodes and idle requests
    run_req(1'b1, 6'd0, 32'h40, 16'd0, 32'h1);
    run_req(1'b1, 6'd13, 32'h44, 16'd0, 32'h2);
    run_req(1'b1, 6'd63, 32'h48, 16'd0, 32'h3);
    run_req(1'b0, 6'd10, 32'h40, 16'd0, 32'h4);
    run_req(1'b0, 6'd22, 32'h44, 16'd0, 32'hFFFF_FFFF);
    // confirm the dropped store left memory untouched
    run_req(1'b1, 6'd10, 32'h44, 16'd0, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule